// File: doc/BRIEF.md
# Predicated Component Write Enable

This block decides which of the four components (x, y, z, w) of a shader instruction's destination are actually written. It decodes the first two 32-bit words of an instruction: the destination word carries the component mask, a no-destination flag and a request to record the result's condition; the second word carries a 3-bit condition test and a per-component selector into the stored condition state.

A four-entry condition register holds, for each component, whether the last recorded result was below, equal to or above zero. Each destination component whose mask bit is set is written only when the condition entry picked by its selector passes the test. The result's per-component sign and zero flags come in from the arithmetic unit, and the block records them when the instruction asks. The output is a 4-bit write enable for the register file. A test of "always" with selectors x, y, z, w in order leaves the mask alone in control.

Top module: `cc_write_gate`

## Requirements
- R1: Word 0 bits 9, 10, 11 and 12 enable components x, y, z and w. A write enable bit is never high unless its mask bit is set. With the test field at 7 (always), the write enable equals the mask.
- R2: When word 0 bit 30 (no destination) is set, the write enable is 4'b0000.
- R3: When instValid is low, the write enable is 4'b0000 and the condition register does not change.
- R4: Word 1 bits 18–20 form the test. Bit 18 passes a below-zero entry, bit 19 an equal-to-zero entry and bit 20 an above-zero entry. The value 0 passes nothing and the value 7 passes everything.
- R5: Word 1 holds a 2-bit selector for each destination component: bits 21–22 for x, 23–24 for y, 25–26 for z and 27–28 for w. A selector value of 0, 1, 2 or 3 picks condition entry x, y, z or w.
- R6: When instValid is high and word 0 bit 8 is set, every condition entry takes a new class at the next clock edge. The class is equal when that component's zero flag is set; otherwise it is below when the sign flag is set; otherwise it is above.
- R7: An instruction's test uses the condition state from before its own update.
- R8: The update covers all four entries, whatever the mask, and also happens when the no-destination bit is set.
- R9: A synchronous reset sets all four condition entries to equal.
- R10: When word 0 bit 8 is clear, the condition register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instValid | input | 1 | The instruction words are valid this cycle |
| instWord0 | input | 32 | Destination word: update request, mask, no-destination flag |
| instWord1 | input | 32 | Source word: condition test and condition selectors |
| resNeg | input | 4 | Per-component result sign flag (bit 0 = x) |
| resZero | input | 4 | Per-component result zero flag (bit 0 = x) |
| wrEn | output | 4 | Final component write enable (bit 0 = x) |

## Verification
The hardest situation to reach is an instruction that both records a new condition and tests the old one. Telling the two apart needs condition entries that differ from each other, and the test must give a different answer on the old state than on the new. The stimulus first loads a mixed below/above/equal state, with a zero mask, through one update. It then runs an update whose new flags would flip the result of its own test. Swizzles that reverse or broadcast the entries follow, so that each selector is shown to reach the entry it names.

// File: rtl/cc_gate_pkg.sv
package cc_gate_pkg;
  localparam int NUM_COMP = 4;
  localparam int WORD_W = 32;
  localparam int TEST_W = 3;
  localparam int SEL_W = $clog2(NUM_COMP);

  // bit positions a neighbouring decoder relies on
  localparam int UPD_BIT = 8;
  localparam int MASK_LSB = 9;
  localparam int NODEST_BIT = 30;
  localparam int TEST_LSB = 18;
  localparam int SEL_LSB = 21;

  // one-hot class, bit order matches the test field bits
  typedef enum logic [TEST_W-1:0] {
    CLS_LT = 3'b001,
    CLS_EQ = 3'b010,
    CLS_GT = 3'b100
  } ccClass_e;

  typedef struct packed {
    logic                            update;
    logic                            writeOk;
    logic [NUM_COMP-1:0]             mask;
    logic [TEST_W-1:0]               test;
    logic [NUM_COMP-1:0][SEL_W-1:0]  sel;
  } ccStrobes_t;
endpackage

// File: rtl/cc_gate_ctrl.sv
module cc_gate_ctrl
  import cc_gate_pkg::*;
(
  input  logic              instValid,
  input  logic [WORD_W-1:0] instWord0,
  input  logic [WORD_W-1:0] instWord1,
  output ccStrobes_t        strb
);
  always_comb begin
    strb.update  = instValid & instWord0[UPD_BIT];
    strb.writeOk = instValid & ~instWord0[NODEST_BIT];
    strb.mask    = instWord0[MASK_LSB +: NUM_COMP];
    strb.test    = instWord1[TEST_LSB +: TEST_W];
    for (int c = 0; c < NUM_COMP; c++)
      strb.sel[c] = instWord1[SEL_LSB + c*SEL_W +: SEL_W];
  end
endmodule

// File: rtl/cc_gate_datapath.sv
module cc_gate_datapath
  import cc_gate_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  ccStrobes_t                      strb,
  input  logic [NUM_COMP-1:0]             resNeg,
  input  logic [NUM_COMP-1:0]             resZero,
  output logic [NUM_COMP-1:0]             wrEn,
  output logic [NUM_COMP-1:0][TEST_W-1:0] ccCur
);
  logic [NUM_COMP-1:0][TEST_W-1:0] ccReg;

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_lane
    logic [TEST_W-1:0] classNext;
    logic [TEST_W-1:0] picked;

    always_comb begin
      if (resZero[c])     classNext = CLS_EQ;
      else if (resNeg[c]) classNext = CLS_LT;
      else                classNext = CLS_GT;
    end

    always_ff @(posedge clk) begin
      if (rst)              ccReg[c] <= CLS_EQ;
      else if (strb.update) ccReg[c] <= classNext;
    end

    assign picked  = ccReg[strb.sel[c]];
    assign wrEn[c] = strb.writeOk & strb.mask[c] & (|(picked & strb.test));
  end

  assign ccCur = ccReg;
endmodule

// File: rtl/cc_write_gate.sv
module cc_write_gate
  import cc_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [WORD_W-1:0] instWord0,
  input  logic [WORD_W-1:0] instWord1,
  input  logic [NUM_COMP-1:0] resNeg,
  input  logic [NUM_COMP-1:0] resZero,
  output logic [NUM_COMP-1:0] wrEn
);
  ccStrobes_t strb;
  logic [NUM_COMP-1:0][TEST_W-1:0] ccCur;

  cc_gate_ctrl u_ctrl (
    .instValid(instValid),
    .instWord0(instWord0),
    .instWord1(instWord1),
    .strb(strb)
  );

  cc_gate_datapath u_dp (
    .clk(clk),
    .rst(rst),
    .strb(strb),
    .resNeg(resNeg),
    .resZero(resZero),
    .wrEn(wrEn),
    .ccCur(ccCur)
  );
endmodule

// File: rtl/cc_write_gate_chk.sv
module cc_write_gate_chk
  import cc_gate_pkg::*;
(
  input logic                            clk,
  input logic                            rst,
  input logic                            instValid,
  input logic [WORD_W-1:0]               instWord0,
  input logic [WORD_W-1:0]               instWord1,
  input logic [NUM_COMP-1:0]             wrEn,
  input logic [NUM_COMP-1:0][TEST_W-1:0] ccCur
);
  for (genvar c = 0; c < NUM_COMP; c++) begin : g_oh
    assert_class_onehot_R6: assert property (@(posedge clk) disable iff (rst)
      $onehot(ccCur[c]));
  end

  assert_reset_equal_R9: assert property (@(posedge clk)
    rst |=> (ccCur == {NUM_COMP{CLS_EQ}}));

  assert_no_dest_R2: assert property (@(posedge clk) disable iff (rst)
    instWord0[NODEST_BIT] |-> (wrEn == '0));

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !instValid |-> (wrEn == '0));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !instValid |=> $stable(ccCur));

  assert_no_update_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (instValid && !instWord0[UPD_BIT]) |=> $stable(ccCur));

  assert_within_mask_R1: assert property (@(posedge clk) disable iff (rst)
    (wrEn & ~instWord0[MASK_LSB +: NUM_COMP]) == '0);

  assert_never_test_R4: assert property (@(posedge clk) disable iff (rst)
    (instWord1[TEST_LSB +: TEST_W] == '0) |-> (wrEn == '0));

  assert_always_test_R4: assert property (@(posedge clk) disable iff (rst)
    (instValid && !instWord0[NODEST_BIT] && instWord1[TEST_LSB +: TEST_W] == 3'd7)
      |-> (wrEn == instWord0[MASK_LSB +: NUM_COMP]));
endmodule

bind cc_write_gate cc_write_gate_chk u_chk (
  .clk(clk),
  .rst(rst),
  .instValid(instValid),
  .instWord0(instWord0),
  .instWord1(instWord1),
  .wrEn(wrEn),
  .ccCur(ccCur)
);

// File: tb/tb_cc_write_gate.sv
module tb_cc_write_gate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instValid = 1'b0;
  logic [31:0] instWord0 = '0;
  logic [31:0] instWord1 = '0;
  logic [3:0] resNeg = '0;
  logic [3:0] resZero = '0;
  logic [3:0] wrEn;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  cc_write_gate dut (
    .clk(clk), .rst(rst), .instValid(instValid),
    .instWord0(instWord0), .instWord1(instWord1),
    .resNeg(resNeg), .resZero(resZero), .wrEn(wrEn)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic        upd;
    logic        nd;
    logic [3:0]  mask;
    logic [2:0]  test;
    logic [7:0]  sel;
    logic [3:0]  neg;
    logic [3:0]  zero;
    logic [3:0]  expect_;
  } vec_t;

  // test: 0 never,1 lt,2 eq,3 le,4 gt,5 ne,6 ge,7 always; sel 8'hE4 = x,y,z,w
  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{" R1", 0, 0, 4'hF, 3'd7, 8'hE4, 4'h0, 4'h0, 4'hF},
    '{" R1", 0, 0, 4'h5, 3'd7, 8'hE4, 4'h0, 4'h0, 4'h5},
    '{" R4", 0, 0, 4'hF, 3'd0, 8'hE4, 4'h0, 4'h0, 4'h0},
    '{" R4", 0, 0, 4'hF, 3'd2, 8'hE4, 4'h0, 4'h0, 4'hF},
    '{" R4", 0, 0, 4'hF, 3'd5, 8'hE4, 4'h0, 4'h0, 4'h0},
    // R8: load x=LT y=GT z=EQ w=EQ with mask 0
    '{" R8", 1, 0, 4'h0, 3'd7, 8'hE4, 4'h9, 4'hC, 4'h0},
    '{" R6", 0, 0, 4'hF, 3'd1, 8'hE4, 4'h0, 4'h0, 4'h1},
    '{" R6", 0, 0, 4'hF, 3'd4, 8'hE4, 4'h0, 4'h0, 4'h2},
    '{" R4", 0, 0, 4'hF, 3'd6, 8'hE4, 4'h0, 4'h0, 4'hE},
    '{" R4", 0, 0, 4'hF, 3'd3, 8'hE4, 4'h0, 4'h0, 4'hD},
    '{" R5", 0, 0, 4'hF, 3'd4, 8'h55, 4'h0, 4'h0, 4'hF},
    '{" R5", 0, 0, 4'h6, 3'd1, 8'h00, 4'h0, 4'h0, 4'h6},
    '{" R5", 0, 0, 4'hF, 3'd2, 8'h1B, 4'h0, 4'h0, 4'h3},
    // R7: update to all GT, test LT against old state
    '{" R7", 1, 0, 4'hF, 3'd1, 8'hE4, 4'h0, 4'h0, 4'h1},
    '{" R7", 0, 0, 4'hF, 3'd4, 8'hE4, 4'h0, 4'h0, 4'hF},
    // R2 and R8: no destination still updates (all EQ)
    '{" R2", 1, 1, 4'hF, 3'd7, 8'hE4, 4'h0, 4'hF, 4'h0},
    '{" R8", 0, 0, 4'hF, 3'd2, 8'hE4, 4'h0, 4'h0, 4'hF},
    // R10: flags ignored without update request
    '{"R10", 0, 0, 4'hF, 3'd7, 8'hE4, 4'hF, 4'h0, 4'hF},
    '{"R10", 0, 0, 4'hF, 3'd2, 8'hE4, 4'h0, 4'h0, 4'hF}
  };

  function automatic logic [31:0] mkW0(logic upd, logic nd, logic [3:0] mask);
    return (32'(upd) << 8) | (32'(mask) << 9) | (32'(nd) << 30);
  endfunction

  function automatic logic [31:0] mkW1(logic [2:0] test, logic [7:0] sel);
    return (32'(test) << 18) | (32'(sel) << 21);
  endfunction

  task automatic drive(logic v, logic upd, logic nd, logic [3:0] mask,
                       logic [2:0] test, logic [7:0] sel,
                       logic [3:0] neg, logic [3:0] zero);
    @(negedge clk);
    instValid = v;
    instWord0 = mkW0(upd, nd, mask);
    instWord1 = mkW1(test, sel);
    resNeg = neg;
    resZero = zero;
    #1;
  endtask

  task automatic check(string tag, logic [3:0] exp);
    nChecks++;
    if (wrEn !== exp) begin
      nFails++;
      $display("FAIL %s: wrEn=%b expected=%b", tag, wrEn, exp);
    end
  endtask

  initial begin : watchdog
    #400000;
    nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    // reset state: idle outputs nothing
    drive(0, 0, 0, 4'hF, 3'd7, 8'hE4, 4'h0, 4'h0);
    check("R3", 4'h0);
    repeat (2) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(1, VEC[i].upd, VEC[i].nd, VEC[i].mask, VEC[i].test, VEC[i].sel,
            VEC[i].neg, VEC[i].zero);
      check(string'(VEC[i].tag), VEC[i].expect_);
    end

    // R3: idle cycle with update request and below-zero flags changes nothing
    drive(0, 1, 0, 4'hF, 3'd7, 8'hE4, 4'hF, 4'h0);
    check("R3", 4'h0);
    drive(1, 0, 0, 4'hF, 3'd2, 8'hE4, 4'h0, 4'h0);
    check("R3", 4'hF);

    // R6: zero flag wins over sign flag; plain above for x
    drive(1, 1, 0, 4'h0, 3'd7, 8'hE4, 4'hE, 4'h2);
    check("R6", 4'h0);
    drive(1, 0, 0, 4'hF, 3'd1, 8'hE4, 4'h0, 4'h0);
    check("R6", 4'hC);
    drive(1, 0, 0, 4'hF, 3'd4, 8'hE4, 4'h0, 4'h0);
    check("R6", 4'h1);

    // R9: reset returns all entries to equal
    drive(1, 1, 0, 4'h0, 3'd7, 8'hE4, 4'h0, 4'h0);
    @(negedge clk);
    rst = 1'b1;
    instValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    drive(1, 0, 0, 4'hF, 3'd2, 8'hE4, 4'h0, 4'h0);
    check("R9", 4'hF);
    drive(1, 0, 0, 4'hF, 3'd4, 8'hE4, 4'h0, 4'h0);
    check("R9", 4'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule